// File: doc/BRIEF.md
# Palette-Indexed Video Pixel Shifter

This block turns a 32-bit pixel pattern and a 32-bit colour palette into a stream of 8-bit colour codes. It steps once for every cycle in which both the pixel-clock enable and the block enable are high. A producer offers a palette word and a pattern word on a ready/valid handshake. The handshake completes only on the last tick of the frame now being shown. If no word is waiting at that moment, the block shows the previous palette and pattern again.

A mode input selects 2 bits per pixel or 1 bit per pixel. In 2-bit mode the pattern holds 16 pixels. In 1-bit mode it holds 32 pixels and only the two low palette bytes can be reached. A scale setting has two fields. One gives the number of ticks each pixel lasts. The other gives the number of ticks in a whole frame, and that number is independent of the pixel length. A frame can therefore show only a low-order prefix of the pattern, or keep showing its top pixel, so one handoff can produce a long sync or porch span. The colour byte leaves the block unchanged as RRGGBBHV, which means sync levels are ordinary palette entries.

Top module: `pal_pixel_shifter`

## Requirements
- R1: After reset the output is 0 and `in_ready` is low until the first tick. The reset state is an empty frame one tick long, so that first tick is a frame end.
- R2: With `mode_2bpp`=1, pixel k is pattern bits [2k+1:2k], starting at k=0. Index value v selects palette bits [8v+7:8v].
- R3: With `mode_2bpp`=0, pixel k is pattern bit k, starting at k=0. A 0 selects palette bits [7:0] and a 1 selects bits [15:8].
- R4: Each pixel lasts `clk_per_pix` ticks and each frame lasts `clk_per_frame` ticks. A value of 0 in either field counts as 1.
- R5: When the frame ends before the pattern is used up, only the low-order pixels are shown. For example, 16 ticks per pixel and 160 ticks per frame show pixels 0 to 9.
- R6: When the frame outlasts the pattern, the most significant pixel stays on the output until the frame ends.
- R7: `in_ready` is high exactly on a tick that is the last tick of a frame. A word offered with `in_valid` in that cycle is shown from the next tick.
- R8: If `in_valid` is low at a frame end, the next frame shows the previous palette and pattern again.
- R9: Scale fields and mode are sampled only when a frame starts. Changes made mid-frame take effect at the next frame.
- R10: A cycle with `pix_ce` low changes neither the output nor the frame position.
- R11: With `enable` low, the output is 0, `in_ready` is low and the frame position is frozen.
- R12: The selected palette byte is output unchanged, with bits 7..0 in the order R1 R0 G1 G0 B1 B0 H V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Block enable; when low the output is forced to 0 |
| pix_ce | input | 1 | Pixel-clock enable (one tick) |
| mode_2bpp | input | 1 | 1: 2 bits per pixel, 0: 1 bit per pixel |
| clk_per_pix | input | 8 | Ticks per pixel |
| clk_per_frame | input | 12 | Ticks per frame |
| in_valid | input | 1 | Producer offers a palette and pattern |
| in_ready | output | 1 | Handoff accepted this cycle |
| in_palette | input | 32 | Four colour bytes, index 0 in the low byte |
| in_pattern | input | 32 | Pixel indices, first pixel in the low bits |
| color_out | output | 8 | RRGGBBHV colour code |

## Verification
Two events can fall in the same tick: a frame ends, which may take a new handoff and re-sample the scale and mode, and a pixel boundary is reached. With some scale settings the frame ends in the middle of a pixel instead. The random phase changes the scale fields, mode and valid on every cycle, with short frames and pixel lengths that often do not divide the frame. This makes frame ends land both on and off pixel boundaries, sometimes with a handoff and sometimes without. A bench model derives the expected pixel from the tick position within the frame. Each cycle the bench compares that model against the output and against `in_ready`.

// File: rtl/pal_pixel_shifter.sv
module pal_pixel_shifter #(
  parameter int CPP_W = 8,
  parameter int CPF_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             pix_ce,
  input  logic             mode_2bpp,
  input  logic [CPP_W-1:0] clk_per_pix,
  input  logic [CPF_W-1:0] clk_per_frame,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_palette,
  input  logic [31:0]      in_pattern,
  output logic [7:0]       color_out
);
  logic [31:0]      pal_q, pat_q;
  logic [CPP_W-1:0] cpp_q, pcnt;
  logic [CPF_W-1:0] cpf_q, fcnt;
  logic             mode_q;
  logic [4:0]       pidx, max_idx;
  logic [1:0]       sel;
  logic             tick, frame_end, pix_end, take;

  assign tick      = enable & pix_ce;
  assign frame_end = (fcnt == cpf_q - 1'b1);
  assign pix_end   = (pcnt == cpp_q - 1'b1);
  assign in_ready  = tick & frame_end;
  assign take      = in_ready & in_valid;
  assign max_idx   = mode_q ? 5'd15 : 5'd31;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pal_q  <= '0;
      pat_q  <= '0;
      cpp_q  <= CPP_W'(1);
      cpf_q  <= CPF_W'(1);
      mode_q <= 1'b1;
      pcnt   <= '0;
      fcnt   <= '0;
      pidx   <= '0;
    end else if (tick) begin
      if (frame_end) begin
        if (take) begin
          pal_q <= in_palette;
          pat_q <= in_pattern;
        end
        cpp_q  <= (clk_per_pix == '0) ? CPP_W'(1) : clk_per_pix;
        cpf_q  <= (clk_per_frame == '0) ? CPF_W'(1) : clk_per_frame;
        mode_q <= mode_2bpp;
        pcnt   <= '0;
        fcnt   <= '0;
        pidx   <= '0;
      end else begin
        fcnt <= fcnt + 1'b1;
        if (pix_end) begin
          pcnt <= '0;
          if (pidx != max_idx) pidx <= pidx + 1'b1;
        end else begin
          pcnt <= pcnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (mode_q) sel = pat_q[{pidx[3:0], 1'b0} +: 2];
    else        sel = {1'b0, pat_q[pidx]};
  end

  assign color_out = enable ? pal_q[{sel, 3'b000} +: 8] : 8'h00;

  a_r11_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (color_out == 8'h00 && !in_ready));
  a_r7_ready_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (pix_ce && enable));
  a_r10_frozen_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(fcnt) && $stable(pidx) && $stable(pal_q)));
  a_r9_scale_held_midframe: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> ($stable(cpp_q) && $stable(cpf_q) && $stable(mode_q)));
  a_r8_repeat_on_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> ($stable(pal_q) && $stable(pat_q)));
  a_r4_counters_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (pcnt < cpp_q) && (fcnt < cpf_q));
  a_r6_index_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    pidx <= max_idx);
endmodule

// File: tb/test_pal_pixel_shifter.sv
`timescale 1ns/1ps
module test_pal_pixel_shifter;
  logic clk = 0, rst_n = 0, enable = 0, pix_ce = 0, mode_2bpp = 1, in_valid = 0;
  logic [7:0] clk_per_pix = 1;
  logic [11:0] clk_per_frame = 1;
  logic [31:0] in_palette = 0, in_pattern = 0;
  logic in_ready;
  logic [7:0] color_out;
  int n_chk = 0, n_bad = 0;

  logic [31:0] m_pal, m_pat;
  int m_cpp, m_cpf, m_t;
  bit m_mode;

  always #2.5 clk = ~clk;

  pal_pixel_shifter i_pal_pixel_shifter (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pix_ce(pix_ce), .mode_2bpp(mode_2bpp),
    .clk_per_pix(clk_per_pix), .clk_per_frame(clk_per_frame), .in_valid(in_valid),
    .in_ready(in_ready), .in_palette(in_palette), .in_pattern(in_pattern),
    .color_out(color_out));

  function automatic logic [7:0] exp_color();
    int npix = m_mode ? 16 : 32;
    int idx = m_t / m_cpp;
    int s;
    if (idx > npix - 1) idx = npix - 1;
    s = m_mode ? int'((m_pat >> (2 * idx)) & 32'h3) : int'((m_pat >> idx) & 32'h1);
    return 8'((m_pal >> (8 * s)) & 32'hff);
  endfunction

  task automatic check(input string tag, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic step(input bit en, input bit ce, input bit val, input bit md,
                      input logic [7:0] cp, input logic [11:0] cf,
                      input logic [31:0] pl, input logic [31:0] pt, input string tag);
    @(negedge clk);
    enable = en; pix_ce = ce; in_valid = val; mode_2bpp = md;
    clk_per_pix = cp; clk_per_frame = cf; in_palette = pl; in_pattern = pt;
    #1;
    check(tag, "color", color_out, en ? exp_color() : 8'h00);
    check("R7", "ready", in_ready, (en && ce && (m_t + 1 == m_cpf)) ? 1 : 0);
    @(posedge clk);
    if (en && ce) begin
      if (m_t + 1 >= m_cpf) begin
        if (val) begin m_pal = pl; m_pat = pt; end
        m_cpp = (cp == 0) ? 1 : int'(cp);
        m_cpf = (cf == 0) ? 1 : int'(cf);
        m_mode = md;
        m_t = 0;
      end else m_t++;
    end
  endtask

  task automatic phase(input int n, input bit val, input bit md, input logic [7:0] cp,
                       input logic [11:0] cf, input logic [31:0] pl, input logic [31:0] pt,
                       input string tag);
    for (int i = 0; i < n; i++) step(1, 1, val, md, cp, cf, pl, pt, tag);
  endtask

  initial begin
    #900us;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_pal = 0; m_pat = 0; m_cpp = 1; m_cpf = 1; m_mode = 1; m_t = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1; enable = 1; pix_ce = 0;
    #1;
    check("R1", "color", color_out, 0);
    check("R1", "ready", in_ready, 0);
    step(1, 0, 0, 1, 1, 16, 0, 0, "R1");
    // R2: 2bpp, distinct bytes, every index pattern
    phase(40, 1, 1, 1, 16, 32'hC3_5A_81_24, 32'h1B_E4_93_6C, "R2");
    // R8: no new data, same frame repeats
    phase(40, 0, 1, 1, 16, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R8");
    // R5: prefix of 10 pixels
    phase(400, 1, 1, 16, 160, 32'h03_02_01_00, 32'hFFF6_9A5C, "R5");
    // R6: hold most significant pixel
    phase(100, 1, 1, 1, 40, 32'hAA_55_0F_F0, 32'h8000_1234, "R6");
    // R3: 1bpp, 32 pixels, then stretched with hold
    phase(80, 1, 0, 1, 32, 32'hDE_AD_3C_C3, 32'hA5F0_0F96, "R3");
    phase(160, 1, 0, 2, 70, 32'h11_22_33_44, 32'h8001_7E81, "R3");
    // R4: zero fields count as one, odd lengths
    phase(60, 1, 1, 0, 5, 32'h01_02_03_04, 32'h0000_00E4, "R4");
    phase(60, 1, 1, 3, 0, 32'h10_20_30_40, 32'h0000_0039, "R4");
    phase(90, 1, 1, 3, 20, 32'h10_20_30_40, 32'h0000_0039, "R4");
    // R12: sync bits pass through
    phase(60, 1, 1, 2, 8, 32'h01_02_FC_03, 32'h0000_0036, "R12");
    // R10: no pixel clock
    for (int i = 0; i < 20; i++) step(1, 0, 1, 0, 1, 2, 32'h77, 32'h1, "R10");
    // R11: disabled
    for (int i = 0; i < 20; i++) step(0, 1, 1, 0, 1, 1, 32'h99, 32'h1, "R11");
    phase(10, 0, 1, 2, 8, 32'h0, 32'h0, "R11");
    // R9: random mix, scale and mode change mid-frame
    for (int i = 0; i < 20000; i++) begin
      bit en = ($urandom % 16) != 0;
      bit ce = ($urandom % 4) != 0;
      bit val = $urandom % 2;
      bit md = $urandom % 2;
      logic [7:0] cp = 8'($urandom % 5);
      logic [11:0] cf = 12'($urandom % 70);
      step(en, ce, val, md, cp, cf, $urandom, $urandom, "R9");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule